// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit sits in the decode stage of a load/store processor. It resolves where an instruction's operand lives. It receives a three-bit addressing-mode code, the index and current value of a base register, a signed 12-bit offset field and the current program counter. From these it produces five results:

- an effective memory address;
- a flag telling the pipeline whether memory must be accessed;
- a flag telling whether the operand is a literal taken from the instruction;
- the operand value itself, for the two non-memory modes;
- an optional write-back of an updated base register, given as an index and a value.

The address arithmetic is a single combinational path that feeds one register stage. A new instruction is accepted only in a cycle where the upstream valid and the downstream ready are both high. While ready is low, the registered results stay unchanged. Register index 15 is the program counter. Any memory mode that names it as the base uses the supplied PC value instead of the register value, and a base update aimed at it is never issued.

Top module: `agu_top`

## Requirements
- R1: Mode code 0 (literal): the operand value is the offset field sign-extended to 32 bits, the literal flag is 1, the memory flag is 0, the address is 0 and no write-back is issued.
- R2: Mode code 1 (register operand): the operand value equals the supplied base register value, the literal flag is 0, the memory flag is 0, the address is 0 and no write-back is issued.
- R3: Mode code 2 (register indirect): the address equals the base value, the memory flag is 1 and no write-back is issued.
- R4: Mode code 3 (base plus offset): the address is the base plus the sign-extended offset, and no write-back is issued.
- R5: Mode code 4 (update before access): the address is the base plus the offset, and the same sum is issued as write-back to the base register index.
- R6: Mode code 5 (update after access): the address is the base value unchanged, and the base plus the offset is issued as write-back to the base register index.
- R7: Mode code 6 (PC relative): the address is the supplied PC plus the sign-extended offset, independent of the base index and base value, and no write-back is issued.
- R8: Mode code 7 (absolute): the address is the 12-bit offset field zero-extended to 32 bits, the memory flag is 1 and no write-back is issued.
- R9: With base index 15 in mode codes 2 to 5, the supplied PC replaces the base value, and the write-back valid flag stays 0.
- R10: All address sums wrap modulo 2^32.
- R11: Registered outputs load only in a cycle where input valid and output ready are both high. Output valid follows input valid in every cycle where ready is high. All outputs hold while ready is low. Input ready equals output ready.
- R12: After synchronous reset every output is 0.
- R13: In all memory modes (codes 2 to 7) the operand value output is 0 and the literal flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction fields are valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_mode | input | 3 | Addressing-mode code 0..7 |
| in_base_idx | input | 4 | Base register index (15 = program counter) |
| in_base_val | input | 32 | Current value of the base register |
| in_imm | input | 12 | Signed offset / literal / absolute field |
| in_pc | input | 32 | Current program counter |
| out_ready | input | 1 | Downstream can take the result |
| out_valid | output | 1 | Result registers hold a valid result |
| out_ea | output | 32 | Effective address |
| out_mem_access | output | 1 | Memory must be accessed |
| out_operand_is_imm | output | 1 | Operand is the instruction literal |
| out_operand_val | output | 32 | Operand value in literal or register mode |
| out_wb_valid | output | 1 | Base register write-back requested |
| out_wb_idx | output | 4 | Write-back register index |
| out_wb_val | output | 32 | Write-back value |

## Verification
In the auto-update modes, address generation and base write-back fall in the same cycle. Both come from one adder, but in update-before-access mode the address takes the sum, while in update-after-access mode the address takes the old base and only the write-back takes the sum. Directed cases use each mode with an ordinary base index and with index 15, and random traffic mixes all modes. The bench judges the address and the write-back value separately against its own model, and it also checks that the write-back flag drops for index 15. Stall cycles, where new inputs arrive while ready is low, are interleaved to show that both results stay frozen together.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AM_LIT   = 3'd0,
        AM_REG   = 3'd1,
        AM_IND   = 3'd2,
        AM_OFS   = 3'd3,
        AM_PRE   = 3'd4,
        AM_POST  = 3'd5,
        AM_PCREL = 3'd6,
        AM_ABS   = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        EA_NONE = 2'd0,
        EA_BASE = 2'd1,
        EA_SUM  = 2'd2,
        EA_ABS  = 2'd3
    } ea_src_e;

    typedef enum logic [1:0] {
        OPV_NONE = 2'd0,
        OPV_LIT  = 2'd1,
        OPV_BASE = 2'd2
    } opv_src_e;

    typedef struct packed {
        logic     mem;
        logic     is_lit;
        logic     wb_en;
        logic     use_pc;
        ea_src_e  ea_src;
        opv_src_e opv_src;
    } agu_ctl_t;

    // Mode-only control; index-dependent rules are applied by the decoder.
    function automatic agu_ctl_t mode_ctl(agu_mode_e m);
        agu_ctl_t c;
        c = '{mem: 1'b0, is_lit: 1'b0, wb_en: 1'b0, use_pc: 1'b0,
              ea_src: EA_NONE, opv_src: OPV_NONE};
        unique case (m)
            AM_LIT:   begin c.is_lit = 1'b1; c.opv_src = OPV_LIT; end
            AM_REG:   begin c.opv_src = OPV_BASE; end
            AM_IND:   begin c.mem = 1'b1; c.ea_src = EA_BASE; end
            AM_OFS:   begin c.mem = 1'b1; c.ea_src = EA_SUM; end
            AM_PRE:   begin c.mem = 1'b1; c.ea_src = EA_SUM;  c.wb_en = 1'b1; end
            AM_POST:  begin c.mem = 1'b1; c.ea_src = EA_BASE; c.wb_en = 1'b1; end
            AM_PCREL: begin c.mem = 1'b1; c.ea_src = EA_SUM;  c.use_pc = 1'b1; end
            AM_ABS:   begin c.mem = 1'b1; c.ea_src = EA_ABS; end
            default:  ;
        endcase
        return c;
    endfunction

    // True for the modes whose base register may be replaced by the PC.
    function automatic logic base_mode(agu_mode_e m);
        return (m == AM_IND) || (m == AM_OFS) || (m == AM_PRE) || (m == AM_POST);
    endfunction

endpackage

// File: rtl/agu_decode.sv
module agu_decode
    import agu_pkg::*;
#(
    parameter int REG_IDX_W = 4
) (
    input  logic [2:0]           mode,
    input  logic [REG_IDX_W-1:0] base_idx,
    output agu_ctl_t             ctl
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = {REG_IDX_W{1'b1}};

    agu_mode_e mode_e;
    logic      idx_is_pc;

    always_comb begin
        mode_e    = agu_mode_e'(mode);
        idx_is_pc = (base_idx == PC_IDX);
        ctl       = mode_ctl(mode_e);
        if (base_mode(mode_e) && idx_is_pc) begin
            ctl.use_pc = 1'b1;
            ctl.wb_en  = 1'b0;
        end
    end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              use_pc,
    input  logic              wb_en,
    input  ea_src_e           ea_src,
    input  opv_src_e          opv_src,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  imm,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] opv,
    output logic [ADDR_W-1:0] wb_val
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_sx;
    logic [ADDR_W-1:0] off_zx;
    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] sum;

    generate
        if (EXT_W > 0) begin : g_ext
            assign off_sx = {{EXT_W{imm[OFF_W-1]}}, imm};
            assign off_zx = {{EXT_W{1'b0}}, imm};
        end else begin : g_trunc
            assign off_sx = imm[ADDR_W-1:0];
            assign off_zx = imm[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        base_eff = use_pc ? pc : base_val;
        sum      = base_eff + off_sx;   // modulo 2^ADDR_W
        unique case (ea_src)
            EA_BASE: ea = base_eff;
            EA_SUM:  ea = sum;
            EA_ABS:  ea = off_zx;
            default: ea = '0;
        endcase
        unique case (opv_src)
            OPV_LIT:  opv = off_sx;
            OPV_BASE: opv = base_val;
            default:  opv = '0;
        endcase
        wb_val = wb_en ? sum : '0;
    end

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
    parameter int ADDR_W    = 32,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 out_ready,
    input  logic [ADDR_W-1:0]    d_ea,
    input  logic                 d_mem,
    input  logic                 d_is_lit,
    input  logic [ADDR_W-1:0]    d_opv,
    input  logic                 d_wb_en,
    input  logic [REG_IDX_W-1:0] d_wb_idx,
    input  logic [ADDR_W-1:0]    d_wb_val,
    output logic                 q_valid,
    output logic [ADDR_W-1:0]    q_ea,
    output logic                 q_mem,
    output logic                 q_is_lit,
    output logic [ADDR_W-1:0]    q_opv,
    output logic                 q_wb_en,
    output logic [REG_IDX_W-1:0] q_wb_idx,
    output logic [ADDR_W-1:0]    q_wb_val
);
    logic load;
    assign load = in_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid  <= 1'b0;
            q_ea     <= '0;
            q_mem    <= 1'b0;
            q_is_lit <= 1'b0;
            q_opv    <= '0;
            q_wb_en  <= 1'b0;
            q_wb_idx <= '0;
            q_wb_val <= '0;
        end else begin
            if (out_ready) q_valid <= in_valid;
            if (load) begin
                q_ea     <= d_ea;
                q_mem    <= d_mem;
                q_is_lit <= d_is_lit;
                q_opv    <= d_opv;
                q_wb_en  <= d_wb_en;
                q_wb_idx <= d_wb_en ? d_wb_idx : '0;
                q_wb_val <= d_wb_val;
            end
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        !out_ready |=> $stable(q_valid) && $stable(q_ea) && $stable(q_wb_val)); // R11
    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
        out_ready |=> q_valid == $past(in_valid)); // R11

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 12,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_mode,
    input  logic [REG_IDX_W-1:0] in_base_idx,
    input  logic [ADDR_W-1:0]    in_base_val,
    input  logic [OFF_W-1:0]     in_imm,
    input  logic [ADDR_W-1:0]    in_pc,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_ea,
    output logic                 out_mem_access,
    output logic                 out_operand_is_imm,
    output logic [ADDR_W-1:0]    out_operand_val,
    output logic                 out_wb_valid,
    output logic [REG_IDX_W-1:0] out_wb_idx,
    output logic [ADDR_W-1:0]    out_wb_val
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = {REG_IDX_W{1'b1}};

    agu_ctl_t          ctl;
    logic [ADDR_W-1:0] c_ea;
    logic [ADDR_W-1:0] c_opv;
    logic [ADDR_W-1:0] c_wb_val;

    assign in_ready = out_ready;

    agu_decode #(.REG_IDX_W(REG_IDX_W)) u_dec (
        .mode     (in_mode),
        .base_idx (in_base_idx),
        .ctl      (ctl)
    );

    agu_addr_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_calc (
        .use_pc   (ctl.use_pc),
        .wb_en    (ctl.wb_en),
        .ea_src   (ctl.ea_src),
        .opv_src  (ctl.opv_src),
        .base_val (in_base_val),
        .pc       (in_pc),
        .imm      (in_imm),
        .ea       (c_ea),
        .opv      (c_opv),
        .wb_val   (c_wb_val)
    );

    agu_out_stage #(.ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .d_ea     (c_ea),
        .d_mem    (ctl.mem),
        .d_is_lit (ctl.is_lit),
        .d_opv    (c_opv),
        .d_wb_en  (ctl.wb_en),
        .d_wb_idx (in_base_idx),
        .d_wb_val (c_wb_val),
        .q_valid  (out_valid),
        .q_ea     (out_ea),
        .q_mem    (out_mem_access),
        .q_is_lit (out_operand_is_imm),
        .q_opv    (out_operand_val),
        .q_wb_en  (out_wb_valid),
        .q_wb_idx (out_wb_idx),
        .q_wb_val (out_wb_val)
    );

    AST_WB_NOT_PC: assert property (@(posedge clk) disable iff (rst)
        out_wb_valid |-> out_wb_idx != PC_IDX); // R9
    AST_WB_NEEDS_MEM: assert property (@(posedge clk) disable iff (rst)
        out_wb_valid |-> out_mem_access && !out_operand_is_imm); // R5
    AST_LIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        out_operand_is_imm |-> !out_mem_access && !out_wb_valid); // R1
    AST_PRE_WB_EQ_EA: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_ready && in_mode == AM_PRE && in_base_idx != PC_IDX)
        |=> out_wb_valid && out_wb_val == out_ea); // R5
    AST_POST_EA_BASE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_ready && in_mode == AM_POST && in_base_idx != PC_IDX)
        |=> out_ea == $past(in_base_val)); // R6

endmodule

// File: tb/agu_top_tb.sv
module agu_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_mode;
    logic [3:0]  in_base_idx;
    logic [31:0] in_base_val;
    logic [11:0] in_imm;
    logic [31:0] in_pc;
    logic        out_ready;
    logic        out_valid;
    logic [31:0] out_ea;
    logic        out_mem_access;
    logic        out_operand_is_imm;
    logic [31:0] out_operand_val;
    logic        out_wb_valid;
    logic [3:0]  out_wb_idx;
    logic [31:0] out_wb_val;

    int n_checks = 0;
    int n_fails  = 0;

    // expected registered state
    logic        e_valid, e_mem, e_lit, e_wb;
    logic [31:0] e_ea, e_opv, e_wbv;
    logic [3:0]  e_wbi;

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_base_idx(in_base_idx), .in_base_val(in_base_val),
        .in_imm(in_imm), .in_pc(in_pc), .out_ready(out_ready),
        .out_valid(out_valid), .out_ea(out_ea), .out_mem_access(out_mem_access),
        .out_operand_is_imm(out_operand_is_imm), .out_operand_val(out_operand_val),
        .out_wb_valid(out_wb_valid), .out_wb_idx(out_wb_idx), .out_wb_val(out_wb_val)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(logic [2:0] m, logic [3:0] idx);
        if (idx == 4'd15 && m >= 3'd2 && m <= 3'd5) return "R9";
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] sx(logic [11:0] v);
        return {{20{v[11]}}, v};
    endfunction

    // reference model of one accepted instruction
    task automatic model(logic [2:0] m, logic [3:0] idx, logic [31:0] b,
                         logic [11:0] im, logic [31:0] pc);
        logic [31:0] be;
        be = (idx == 4'd15 && m >= 3'd2 && m <= 3'd5) ? pc : b;
        e_ea = '0; e_opv = '0; e_wb = 1'b0; e_wbv = '0; e_wbi = '0;
        e_mem = (m >= 3'd2);
        e_lit = (m == 3'd0);
        case (m)
            3'd0: e_opv = sx(im);
            3'd1: e_opv = b;
            3'd2: e_ea = be;
            3'd3: e_ea = be + sx(im);
            3'd4: begin e_ea = be + sx(im); e_wb = (idx != 4'd15); end
            3'd5: begin e_ea = be; e_wb = (idx != 4'd15); end
            3'd6: e_ea = pc + sx(im);
            default: e_ea = {20'd0, im};
        endcase
        if (e_wb) begin e_wbv = be + sx(im); e_wbi = idx; end
    endtask

    task automatic check_all(string tag);
        chk(tag, "valid", {31'd0, out_valid}, {31'd0, e_valid});
        chk(tag, "ea", out_ea, e_ea);
        chk(tag, "mem", {31'd0, out_mem_access}, {31'd0, e_mem});
        chk(tag, "lit", {31'd0, out_operand_is_imm}, {31'd0, e_lit});
        chk(tag, "opv", out_operand_val, e_opv);
        chk(tag, "wb", {31'd0, out_wb_valid}, {31'd0, e_wb});
        chk(tag, "wbidx", {28'd0, out_wb_idx}, {28'd0, e_wbi});
        chk(tag, "wbval", out_wb_val, e_wbv);
    endtask

    task automatic cycle(logic v, logic r, logic [2:0] m, logic [3:0] idx,
                         logic [31:0] b, logic [11:0] im, logic [31:0] pc, string tag);
        @(negedge clk);
        in_valid = v; out_ready = r; in_mode = m; in_base_idx = idx;
        in_base_val = b; in_imm = im; in_pc = pc;
        #1;
        chk("R11", "in_ready", {31'd0, in_ready}, {31'd0, r});
        @(posedge clk);
        #1;
        if (r) e_valid = v;
        if (v && r) model(m, idx, b, im, pc);
        check_all((v && r) ? ((tag == "") ? mode_tag(m, idx) : tag) : "R11");
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_mode = '0;
        in_base_idx = '0; in_base_val = '0; in_imm = '0; in_pc = '0;
        repeat (3) @(posedge clk);
        #1;
        e_valid = 0; e_mem = 0; e_lit = 0; e_wb = 0;
        e_ea = '0; e_opv = '0; e_wbv = '0; e_wbi = '0;
        check_all("R12");
        @(negedge clk); rst = 1'b0;

        // directed: each mode
        cycle(1, 1, 3'd0, 4'd3, 32'h1111_0000, 12'hFFC, 32'h0000_8000, "R1");
        cycle(1, 1, 3'd1, 4'd3, 32'hCAFE_F00D, 12'h123, 32'h0000_8000, "R2");
        cycle(1, 1, 3'd2, 4'd5, 32'h0000_4000, 12'h010, 32'h0000_8000, "R3");
        cycle(1, 1, 3'd3, 4'd5, 32'h0000_4000, 12'hFF0, 32'h0000_8000, "R4");
        cycle(1, 1, 3'd4, 4'd1, 32'h0000_1000, 12'h004, 32'h0000_8000, "R5");
        cycle(1, 1, 3'd5, 4'd1, 32'h0000_1000, 12'h004, 32'h0000_8000, "R6");
        cycle(1, 1, 3'd6, 4'd7, 32'h0000_1000, 12'h018, 32'h0000_8000, "R7");
        cycle(1, 1, 3'd7, 4'd7, 32'hFFFF_FFFF, 12'h901, 32'h0000_8000, "R8");
        cycle(1, 1, 3'd2, 4'd9, 32'h0000_0000, 12'h000, 32'h0000_8000, "R13");
        // index 15 in base modes
        cycle(1, 1, 3'd4, 4'd15, 32'h0000_1000, 12'h008, 32'h0000_2000, "R9");
        cycle(1, 1, 3'd5, 4'd15, 32'h0000_1000, 12'h008, 32'h0000_2000, "R9");
        cycle(1, 1, 3'd3, 4'd15, 32'h0000_1000, 12'hFF8, 32'h0000_2000, "R9");
        // wraparound
        cycle(1, 1, 3'd4, 4'd2, 32'hFFFF_FFF0, 12'h020, 32'h0, "R10");
        cycle(1, 1, 3'd3, 4'd2, 32'h0000_0004, 12'hFF8, 32'h0, "R10");
        cycle(1, 1, 3'd6, 4'd2, 32'h0, 12'h7FF, 32'hFFFF_FF00, "R10");
        // stall: new inputs while ready low must not load
        cycle(1, 0, 3'd7, 4'd4, 32'h5, 12'hABC, 32'h9, "R11");
        cycle(0, 0, 3'd0, 4'd4, 32'h5, 12'h001, 32'h9, "R11");
        cycle(0, 1, 3'd1, 4'd4, 32'h5, 12'h001, 32'h9, "R11");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] idx;
            idx = ($urandom % 5 == 0) ? 4'd15 : 4'($urandom);
            cycle(($urandom % 4) != 0, ($urandom % 5) != 0, 3'($urandom), idx,
                  $urandom, 12'($urandom), $urandom, "");
        end
        summary();
    end

endmodule